// File: doc/BRIEF.md
# Read-then-Write Timing Training Sequencer

This block is a calibration sequencer that runs once memory initialization is complete. It trains read capture timing first. To do so it switches the memory into a pattern-readout mode, in which the memory returns a fixed data pattern without any earlier write. It then steps a read strobe delay tap across its whole range. For each tap it asks for the pattern and records whether the read-data comparator reports a match. The final read tap is the midpoint between the first and the last passing taps, which places the strobe near the centre of the data eye.

Write training is optional and runs only after read training has finished. For each write delay tap it writes a known pattern, reads the pattern back, and records the compare result. The final write tap is chosen with the same midpoint rule. If a sweep finds no passing tap, the sequencer stops, raises a fail flag and reports which phase failed.

The controller accepts commands through a valid/ready pair. The bench or the PHY supplies one compare result for each read-type command.

Top module: `timing_train_seq`

## Requirements
- R1: While rst_ni is low, every output is 0: cmd_valid_o, cmd_op_o, rd_tap_o, wr_tap_o, done_o, fail_o and err_code_o.
- R2: A start_i pulse in an idle, done or failed state begins training. The first command is mode-enter (op code 1). It is followed by one pattern-read (op code 3) per read tap, in ascending order from 0 to 63, with rd_tap_o showing that tap while the command is presented.
- R3: Each new tap value is held for a settle time before its command is issued. cmd_valid_o rises exactly settle_cyc_i+1 clocks after the tap output changes. The tap stays stable until its compare result arrives.
- R4: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o and cmd_op_o stay unchanged on the next cycle.
- R5: After the read sweep, a mode-exit command (op code 2) is issued once. If at least one tap passed, rd_tap_o then holds floor((first passing tap + last passing tap)/2).
- R6: When write training is enabled, no write-phase command appears before mode-exit has been accepted. Each write tap from 0 to 63 then gets a write command (op code 4) followed by a read-back command (op code 5), and wr_tap_o ends at floor((first+last)/2) of the passing write taps.
- R7: When wr_train_en_i is low at start, no write or read-back command is issued. wr_tap_o stays 0 and done_o rises after mode-exit.
- R8: If no read tap passes, fail_o rises with err_code_o = 1, rd_tap_o = 0, done_o stays 0, and no write command is issued.
- R9: If write training is enabled and no write tap passes, fail_o rises with err_code_o = 2 and wr_tap_o = 0, while rd_tap_o keeps its trained value.
- R10: done_o and fail_o are never both high. Each one is held until the next start_i pulse, which clears both. A start_i pulse during training is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle training start pulse |
| wr_train_en_i | input | 1 | Enables the write phase (captured at start) |
| settle_cyc_i | input | SETTLE_W | Settle clocks after each tap change (captured at start) |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_op_o | output | 3 | Command: 1 mode-enter, 2 mode-exit, 3 pattern-read, 4 write, 5 read-back |
| cmd_ready_i | input | 1 | Controller accepts the command |
| cmp_valid_i | input | 1 | Compare result valid for the last read-type command |
| cmp_pass_i | input | 1 | Read data matched the expected pattern |
| rd_tap_o | output | TAP_W | Read strobe delay tap |
| wr_tap_o | output | TAP_W | Write delay tap |
| done_o | output | 1 | Training finished successfully |
| fail_o | output | 1 | Training aborted |
| err_code_o | output | 2 | 0 none, 1 read phase failed, 2 write phase failed |

## Verification
The bench builds the block with its defaults: TAP_W = 6, so every run sweeps all 64 taps of both phases, and SETTLE_W = 4, so settle values from 0 to 15 can be used. This makes the extreme windows reachable: a single pass at tap 0, a single pass at tap 63, a window covering every tap, and an empty window in each phase. In each of these cases the bench computes the expected midpoint arithmetically. Runs with settle values 0, 1, 2, 3 and 15, each with cmd_ready_i either always high or toggling, check the exact settle spacing and command hold under back-pressure.

// File: rtl/train_pkg.sv
package train_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_MODE_ENTER = 3'd1,
    OP_MODE_EXIT  = 3'd2,
    OP_PAT_READ   = 3'd3,
    OP_WRITE      = 3'd4,
    OP_READ       = 3'd5
  } train_op_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_READ  = 2'd1,
    ERR_WRITE = 2'd2
  } train_err_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ENTER,
    ST_RD_SETTLE,
    ST_RD_CMD,
    ST_RD_WAIT,
    ST_EXIT,
    ST_WR_SETTLE,
    ST_WR_CMD,
    ST_WR_RD,
    ST_WR_WAIT,
    ST_WR_EVAL,
    ST_DONE,
    ST_FAIL
  } train_state_e;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/tap_window.sv
module tap_window #(
  parameter int TAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             hit_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             found_o,
  output logic [TAP_W-1:0] center_o
);

  logic [TAP_W-1:0] first_q, last_q;
  logic             found_q;
  logic [TAP_W:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      found_q <= 1'b0;
    end else if (clear_i) begin
      first_q <= '0;
      last_q  <= '0;
      found_q <= 1'b0;
    end else if (hit_i) begin
      if (!found_q) first_q <= tap_i;
      last_q  <= tap_i;
      found_q <= 1'b1;
    end
  end

  // rounded-down midpoint
  assign sum      = {1'b0, first_q} + {1'b0, last_q};
  assign center_o = sum[TAP_W:1];
  assign found_o  = found_q;

  // taps sweep upward, so the window never inverts
  p_window_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> (last_q >= first_q));

  p_center_inside_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> (center_o >= first_q && center_o <= last_q));

endmodule

// File: rtl/timing_train_seq.sv
module timing_train_seq
  import train_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int SETTLE_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                wr_train_en_i,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  output logic                cmd_valid_o,
  output logic [2:0]          cmd_op_o,
  input  logic                cmd_ready_i,
  input  logic                cmp_valid_i,
  input  logic                cmp_pass_i,
  output logic [TAP_W-1:0]    rd_tap_o,
  output logic [TAP_W-1:0]    wr_tap_o,
  output logic                done_o,
  output logic                fail_o,
  output logic [1:0]          err_code_o
);

  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam int               NPHASE  = 2;

  train_state_e        state_q, state_d;
  logic [TAP_W-1:0]    rd_tap_q, rd_tap_d, wr_tap_q, wr_tap_d;
  logic                done_q, done_d, fail_q, fail_d;
  train_err_e          err_q, err_d;
  logic                wen_q, wen_d;
  logic [SETTLE_W-1:0] settle_q, settle_d;
  logic                load, clear, expired;
  train_op_e           op;

  logic [NPHASE-1:0]   hit, found;
  logic [TAP_W-1:0]    center [NPHASE];

  assign hit[0] = (state_q == ST_RD_WAIT) && cmp_valid_i && cmp_pass_i;
  assign hit[1] = (state_q == ST_WR_WAIT) && cmp_valid_i && cmp_pass_i;

  for (genvar g = 0; g < NPHASE; g++) begin : g_win
    tap_window #(.TAP_W(TAP_W)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (clear),
      .hit_i    (hit[g]),
      .tap_i    ((g == 0) ? rd_tap_q : wr_tap_q),
      .found_o  (found[g]),
      .center_o (center[g])
    );
  end

  settle_timer #(.CNT_W(SETTLE_W)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .len_i     (settle_q),
    .expired_o (expired)
  );

  always_comb begin
    unique case (state_q)
      ST_ENTER:  op = OP_MODE_ENTER;
      ST_RD_CMD: op = OP_PAT_READ;
      ST_EXIT:   op = OP_MODE_EXIT;
      ST_WR_CMD: op = OP_WRITE;
      ST_WR_RD:  op = OP_READ;
      default:   op = OP_NONE;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    rd_tap_d = rd_tap_q;
    wr_tap_d = wr_tap_q;
    done_d   = done_q;
    fail_d   = fail_q;
    err_d    = err_q;
    wen_d    = wen_q;
    settle_d = settle_q;
    load     = 1'b0;
    clear    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start_i) begin
          clear    = 1'b1;
          state_d  = ST_ENTER;
          rd_tap_d = '0;
          wr_tap_d = '0;
          done_d   = 1'b0;
          fail_d   = 1'b0;
          err_d    = ERR_NONE;
          wen_d    = wr_train_en_i;
          settle_d = settle_cyc_i;
        end
      end
      ST_ENTER: begin
        if (cmd_ready_i) begin
          load    = 1'b1;
          state_d = ST_RD_SETTLE;
        end
      end
      ST_RD_SETTLE: if (expired) state_d = ST_RD_CMD;
      ST_RD_CMD:    if (cmd_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (cmp_valid_i) begin
          if (rd_tap_q == TAP_MAX) begin
            state_d = ST_EXIT;
          end else begin
            rd_tap_d = rd_tap_q + 1'b1;
            load     = 1'b1;
            state_d  = ST_RD_SETTLE;
          end
        end
      end
      ST_EXIT: begin
        if (cmd_ready_i) begin
          if (!found[0]) begin
            rd_tap_d = '0;
            fail_d   = 1'b1;
            err_d    = ERR_READ;
            state_d  = ST_FAIL;
          end else begin
            rd_tap_d = center[0];
            if (wen_q) begin
              wr_tap_d = '0;
              load     = 1'b1;
              state_d  = ST_WR_SETTLE;
            end else begin
              done_d  = 1'b1;
              state_d = ST_DONE;
            end
          end
        end
      end
      ST_WR_SETTLE: if (expired) state_d = ST_WR_CMD;
      ST_WR_CMD:    if (cmd_ready_i) state_d = ST_WR_RD;
      ST_WR_RD:     if (cmd_ready_i) state_d = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (cmp_valid_i) begin
          if (wr_tap_q == TAP_MAX) begin
            state_d = ST_WR_EVAL;
          end else begin
            wr_tap_d = wr_tap_q + 1'b1;
            load     = 1'b1;
            state_d  = ST_WR_SETTLE;
          end
        end
      end
      ST_WR_EVAL: begin
        if (found[1]) begin
          wr_tap_d = center[1];
          done_d   = 1'b1;
          state_d  = ST_DONE;
        end else begin
          wr_tap_d = '0;
          fail_d   = 1'b1;
          err_d    = ERR_WRITE;
          state_d  = ST_FAIL;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rd_tap_q <= '0;
      wr_tap_q <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      err_q    <= ERR_NONE;
      wen_q    <= 1'b0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      rd_tap_q <= rd_tap_d;
      wr_tap_q <= wr_tap_d;
      done_q   <= done_d;
      fail_q   <= fail_d;
      err_q    <= err_d;
      wen_q    <= wen_d;
      settle_q <= settle_d;
    end
  end

  assign cmd_valid_o = (op != OP_NONE);
  assign cmd_op_o    = op;
  assign rd_tap_o    = rd_tap_q;
  assign wr_tap_o    = wr_tap_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign err_code_o  = err_q;

  p_cmd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && cmd_op_o == $past(cmd_op_o)));

  p_rd_tap_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_PAT_READ) |-> $stable(rd_tap_o));

  p_wr_idle_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_PAT_READ) |-> (wr_tap_o == '0));

  p_fail_has_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (err_code_o != ERR_NONE));

  p_done_fail_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  p_done_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

endmodule

// File: tb/timing_train_seq_test.sv
module timing_train_seq_test;

  localparam int TAP_W    = 6;
  localparam int SETTLE_W = 4;
  localparam int NTAP     = 1 << TAP_W;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic                wr_train_en_i = 1'b0;
  logic [SETTLE_W-1:0] settle_cyc_i = '0;
  logic                cmd_valid_o;
  logic [2:0]          cmd_op_o;
  logic                cmd_ready_i = 1'b1;
  logic                cmp_valid_i = 1'b0;
  logic                cmp_pass_i = 1'b0;
  logic [TAP_W-1:0]    rd_tap_o, wr_tap_o;
  logic                done_o, fail_o;
  logic [1:0]          err_code_o;

  timing_train_seq #(.TAP_W(TAP_W), .SETTLE_W(SETTLE_W)) uut (
    .clk_i, .rst_ni, .start_i, .wr_train_en_i, .settle_cyc_i,
    .cmd_valid_o, .cmd_op_o, .cmd_ready_i, .cmp_valid_i, .cmp_pass_i,
    .rd_tap_o, .wr_tap_o, .done_o, .fail_o, .err_code_o
  );

  always #2ns clk_i = ~clk_i;

  int total = 0, bad = 0;
  int lo_r, hi_r, lo_w, hi_w, cfg_settle;
  bit stall;
  int op_cnt [8];
  int rd_exp, wr_exp, seq_bad, gap_bad, hold_bad, order_bad;
  bit exit_seen;
  int resp_cnt = 0, resp_op = 0, gap = 0;
  logic [TAP_W-1:0] prev_rd = '0, prev_wr = '0;
  bit prev_valid = 0, prev_acc = 0;
  logic [2:0] prev_op = '0;

  function automatic bit in_win(int tap, int lo, int hi);
    return (lo <= hi) && (tap >= lo) && (tap <= hi);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory/PHY stand-in, driven and sampled at the falling edge
  always @(negedge clk_i) begin
    bit acc;
    cmd_ready_i = stall ? ~cmd_ready_i : 1'b1;
    cmp_valid_i = 1'b0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0) begin
        cmp_valid_i = 1'b1;
        cmp_pass_i  = (resp_op == 3) ? in_win(int'(rd_tap_o), lo_r, hi_r)
                                     : in_win(int'(wr_tap_o), lo_w, hi_w);
      end
    end
    if (rd_tap_o != prev_rd || wr_tap_o != prev_wr) gap = 0;
    else gap++;
    prev_rd = rd_tap_o;
    prev_wr = wr_tap_o;
    if (prev_valid && !prev_acc && (!cmd_valid_o || cmd_op_o != prev_op)) hold_bad++;
    if (cmd_valid_o && !prev_valid &&
        ((cmd_op_o == 3'd3 && rd_tap_o != 0) || (cmd_op_o == 3'd4 && wr_tap_o != 0)) &&
        gap != cfg_settle + 1) gap_bad++;
    acc = cmd_valid_o && cmd_ready_i;
    if (acc) begin
      op_cnt[cmd_op_o]++;
      case (cmd_op_o)
        3'd2: exit_seen = 1;
        3'd3: begin
          if (int'(rd_tap_o) != rd_exp || exit_seen) seq_bad++;
          rd_exp++;
          resp_cnt = 2; resp_op = 3;
        end
        3'd4: begin
          if (!exit_seen) order_bad++;
          if (int'(wr_tap_o) != wr_exp) seq_bad++;
        end
        3'd5: begin
          if (!exit_seen) order_bad++;
          if (int'(wr_tap_o) != wr_exp) seq_bad++;
          wr_exp++;
          resp_cnt = 2; resp_op = 5;
        end
        default: ;
      endcase
    end
    prev_valid = cmd_valid_o;
    prev_op    = cmd_op_o;
    prev_acc   = acc;
  end

  task automatic run_case(input int lr, hr, lw, hw, input bit wen, input int st,
                          input bit stl, input bit poke);
    bit rd_ok, wr_ok, fin;
    int exp_err, exp_rd, exp_wr, exp_wop;
    lo_r = lr; hi_r = hr; lo_w = lw; hi_w = hw;
    cfg_settle = st; stall = stl;
    foreach (op_cnt[k]) op_cnt[k] = 0;
    rd_exp = 0; wr_exp = 0; seq_bad = 0; gap_bad = 0; hold_bad = 0; order_bad = 0;
    exit_seen = 0;
    rd_ok = (lr <= hr);
    wr_ok = (lw <= hw);
    exp_err = !rd_ok ? 1 : (wen && !wr_ok) ? 2 : 0;
    exp_rd  = rd_ok ? (lr + hr) / 2 : 0;
    exp_wr  = (rd_ok && wen && wr_ok) ? (lw + hw) / 2 : 0;
    exp_wop = (rd_ok && wen) ? NTAP : 0;

    @(negedge clk_i);
    wr_train_en_i = wen;
    settle_cyc_i  = SETTLE_W'(st);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && !fail_o, "R10 start clears flags", {done_o, fail_o}, 0);

    for (int i = 0; i < 30000 && !(done_o || fail_o); i++) begin
      @(negedge clk_i);
      start_i = (poke && i == 200);
    end
    start_i = 1'b0;
    fin = done_o || fail_o;
    chk(fin, "R2 watchdog: training finished", fin, 1);

    chk(op_cnt[1] == 1, "R2/R10 one mode-enter", op_cnt[1], 1);
    chk(op_cnt[3] == NTAP, "R2 pattern-read count", op_cnt[3], NTAP);
    chk(seq_bad == 0, "R2/R6 tap order", seq_bad, 0);
    chk(gap_bad == 0, "R3 settle spacing", gap_bad, 0);
    chk(hold_bad == 0, "R4 command hold", hold_bad, 0);
    chk(op_cnt[2] == 1, "R5 one mode-exit", op_cnt[2], 1);
    chk(order_bad == 0, "R6 write after exit", order_bad, 0);
    chk(op_cnt[4] == exp_wop, "R6/R7/R8 write count", op_cnt[4], exp_wop);
    chk(op_cnt[5] == exp_wop, "R6/R7/R8 read-back count", op_cnt[5], exp_wop);
    chk(int'(rd_tap_o) == exp_rd, "R5/R8 final read tap", rd_tap_o, exp_rd);
    chk(int'(wr_tap_o) == exp_wr, "R6/R7/R9 final write tap", wr_tap_o, exp_wr);
    chk(int'(err_code_o) == exp_err, "R8/R9 error code", err_code_o, exp_err);
    chk(fail_o == (exp_err != 0), "R8/R9 fail flag", fail_o, exp_err != 0);
    chk(done_o == (exp_err == 0), "R7 done flag", done_o, exp_err == 0);

    repeat (20) @(negedge clk_i);
    chk(done_o == (exp_err == 0) && fail_o == (exp_err != 0), "R10 flags held",
        {done_o, fail_o}, {exp_err == 0, exp_err != 0});
  endtask

  initial begin
    stall = 0; cfg_settle = 0; lo_r = 1; hi_r = 0; lo_w = 1; hi_w = 0;
    repeat (3) @(negedge clk_i);
    chk(!cmd_valid_o && cmd_op_o == 0 && rd_tap_o == 0 && wr_tap_o == 0 &&
        !done_o && !fail_o && err_code_o == 0, "R1 reset state",
        {cmd_valid_o, cmd_op_o, rd_tap_o, wr_tap_o, done_o, fail_o, err_code_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_case( 5, 20, 10, 40, 1,  2, 0, 0);  // R5 R6 mid windows
    run_case( 0,  0, 63, 63, 1,  0, 1, 0);  // edge taps, back-pressure
    run_case( 0, 63,  0, 63, 1,  3, 0, 0);  // full-width windows
    run_case(63, 63,  7,  8, 0,  1, 1, 0);  // R7 write disabled
    run_case( 1,  0,  0, 63, 1,  2, 0, 0);  // R8 read empty
    run_case(10, 11,  1,  0, 1,  0, 0, 0);  // R9 write empty
    run_case(30, 33,  2, 61, 1, 15, 1, 1);  // R3 long settle, R10 start while busy

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule